// File: doc/BRIEF.md
# Two-Player Turn Selector

This block keeps a single registered bit that says which of two players moves next in a game played on a nine-cell grid. A game controller supplies the game phase (waiting or playing), the player chosen to start, a debounced button with a one-cycle strobe, a cursor pointing at a cell, and one occupancy bitmap per player. The controller also supplies a game-over flag with a three-bit winner code.

While the game waits to start, the turn bit tracks the chosen starting player. During play, the bit flips only when a placement is legal. A placement is legal when it targets an existing cell that neither player holds. When the game ends, the bit is reloaded from the winner code, so the next game can begin from a known player.

The output comes straight from a flip-flop with an asynchronous reset. Every path through the next-state logic assigns the bit, so no storage other than that flip-flop is inferred.

Top module: `turn_selector`

## Requirements
- R1: While `rst` is high, `player` is 0, independent of the clock.
- R2: With `rst` low and `playing` low (waiting phase), `player` takes the value of `first_player` at each rising clock edge. This rule overrides every other input.
- R3: In the playing phase with `game_over` low, `player` holds its value unless a move is legal. A move is legal only when all of the following hold: `btn_strobe` is 1, `btn` is 1, `cursor` is below 9, and bit `cursor` is 0 in both `occ_p0` and `occ_p1`. Cursor values 9 to 15 never give a legal move.
- R4: In the playing phase with `game_over` low, each legal move inverts `player` at the next rising edge.
- R5: In the playing phase, `game_over` high takes priority over a legal move in the same cycle, so no toggle happens.
- R6: When `game_over` is high in the playing phase, the winner code sets the result. Code 3'b001 sets `player` to 0 and code 3'b100 sets it to 1 at the next rising edge. Any other code leaves `player` unchanged.
- R7: Bit i of `occ_p0` and `occ_p1` (i from 0 to 8) marks cell i as taken. Only the bit selected by `cursor` affects legality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| playing | input | 1 | 1 = game in progress, 0 = waiting phase |
| first_player | input | 1 | Player who starts the next game |
| btn | input | 1 | Debounced placement button level |
| btn_strobe | input | 1 | One-cycle pulse marking a new button press |
| cursor | input | 4 | Selected cell, 0 to 8 valid |
| occ_p0 | input | 9 | Cells held by player 0 |
| occ_p1 | input | 9 | Cells held by player 1 |
| game_over | input | 1 | Game finished this cycle |
| winner | input | 3 | Winner code, 001 = player 0 wins, 100 = player 1 wins |
| player | output | 1 | Registered current player |

## Verification
Every synchronous result appears on `player` one rising edge after the inputs that cause it. The result comes from one register and has no other pipeline stage. The driver applies each stimulus at a falling edge and queues its expected value. The monitor compares the queued value a quarter period after the next rising edge, so each comparison sees exactly one register update. Reset is asynchronous, so its effect is checked while reset is still asserted and with no clock edge involved.

// File: rtl/turn_pkg.sv
package turn_pkg;

    localparam int unsigned CELLS    = 9;
    localparam int unsigned POS_W    = $clog2(CELLS + 1);
    localparam int unsigned WIN_W    = 3;
    localparam logic [WIN_W-1:0] WIN_P0 = 3'b001;
    localparam logic [WIN_W-1:0] WIN_P1 = 3'b100;

    typedef struct packed {
        logic player;
    } turn_state_t;

    typedef struct packed {
        logic load;
        logic value;
    } win_action_t;

endpackage

// File: rtl/move_check.sv
module move_check
    import turn_pkg::*;
#(
    parameter int unsigned N_CELLS = CELLS,
    parameter int unsigned PW      = POS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn,
    input  logic               btn_strobe,
    input  logic [PW-1:0]      cursor,
    input  logic [N_CELLS-1:0] occ_p0,
    input  logic [N_CELLS-1:0] occ_p1,
    output logic               legal
);

    logic [N_CELLS-1:0] sel;
    logic [N_CELLS-1:0] taken;
    logic               in_range;
    logic               hit;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
        assign sel[i] = (cursor == PW'(i));
    end

    always_comb begin
        taken    = occ_p0 | occ_p1;
        in_range = |sel;
        hit      = |(sel & taken);
        legal    = btn && btn_strobe && in_range && !hit;
    end

    AST_CURSOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cursor >= PW'(N_CELLS)) |-> !legal) else $error("cursor out of range gave legal"); // R3

endmodule

// File: rtl/win_decode.sv
module win_decode
    import turn_pkg::*;
#(
    parameter int unsigned WW = WIN_W
) (
    input  logic          game_over,
    input  logic [WW-1:0] winner,
    output win_action_t   act
);

    always_comb begin
        act.load  = 1'b0;
        act.value = 1'b0;
        if (game_over) begin
            if (winner == WIN_P0) begin
                act.load  = 1'b1;
                act.value = 1'b0;
            end else if (winner == WIN_P1) begin
                act.load  = 1'b1;
                act.value = 1'b1;
            end
        end
    end

endmodule

// File: rtl/turn_selector.sv
module turn_selector
    import turn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             playing,
    input  logic             first_player,
    input  logic             btn,
    input  logic             btn_strobe,
    input  logic [POS_W-1:0] cursor,
    input  logic [CELLS-1:0] occ_p0,
    input  logic [CELLS-1:0] occ_p1,
    input  logic             game_over,
    input  logic [WIN_W-1:0] winner,
    output logic             player
);

    turn_state_t st_d, st_q;
    logic        legal;
    win_action_t win_act;

    move_check #(.N_CELLS(CELLS), .PW(POS_W)) u_move (
        .clk       (clk),
        .rst       (rst),
        .btn       (btn),
        .btn_strobe(btn_strobe),
        .cursor    (cursor),
        .occ_p0    (occ_p0),
        .occ_p1    (occ_p1),
        .legal     (legal)
    );

    win_decode #(.WW(WIN_W)) u_win (
        .game_over(game_over),
        .winner   (winner),
        .act      (win_act)
    );

    always_comb begin
        st_d = st_q;
        if (!playing) begin
            st_d.player = first_player;
        end else if (game_over) begin
            if (win_act.load) begin
                st_d.player = win_act.value;
            end
        end else if (legal) begin
            st_d.player = ~st_q.player;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign player = st_q.player;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |-> !player) else $error("player not 0 in reset"); // R1
    AST_WAIT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !playing |=> (player == $past(first_player))) else $error("waiting phase mismatch"); // R2
    AST_HOLD_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (playing && !game_over && !legal) |=> $stable(player)) else $error("turn changed without move"); // R3
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (playing && !game_over && legal) |=> (player != $past(player))) else $error("legal move no toggle"); // R4
    AST_OVER_P0: assert property (@(posedge clk) disable iff (rst)
        (playing && game_over && winner == WIN_P0) |=> !player) else $error("win code 001 not applied"); // R6
    AST_OVER_P1: assert property (@(posedge clk) disable iff (rst)
        (playing && game_over && winner == WIN_P1) |=> player) else $error("win code 100 not applied"); // R6
    AST_OVER_OTHER: assert property (@(posedge clk) disable iff (rst)
        (playing && game_over && winner != WIN_P0 && winner != WIN_P1) |=> $stable(player))
        else $error("other code changed turn"); // R5

endmodule

// File: tb/turn_selector_test.sv
module turn_selector_test;

    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       playing = 1'b0;
    logic       first_player = 1'b0;
    logic       btn = 1'b0;
    logic       btn_strobe = 1'b0;
    logic [3:0] cursor = '0;
    logic [8:0] occ_p0 = '0;
    logic [8:0] occ_p1 = '0;
    logic       game_over = 1'b0;
    logic [2:0] winner = '0;
    logic       player;

    int checks = 0;
    int fails  = 0;
    logic exp_player = 1'b0;

    typedef struct {
        logic  val;
        string req;
    } item_t;
    item_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    turn_selector uut (
        .clk(clk), .rst(rst), .playing(playing), .first_player(first_player),
        .btn(btn), .btn_strobe(btn_strobe), .cursor(cursor),
        .occ_p0(occ_p0), .occ_p1(occ_p1), .game_over(game_over),
        .winner(winner), .player(player)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: player=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the model result.
    task automatic step(input logic pl, input logic fp, input logic b, input logic s,
                        input logic [3:0] cur, input logic [8:0] o0, input logic [8:0] o1,
                        input logic go, input logic [2:0] w, input string req);
        logic lg;
        @(negedge clk);
        playing = pl; first_player = fp; btn = b; btn_strobe = s; cursor = cur;
        occ_p0 = o0; occ_p1 = o1; game_over = go; winner = w;
        lg = b && s && (cur < 4'd9) && !(cur < 4'd9 && (o0[cur] || o1[cur]));
        if (!pl) exp_player = fp;
        else if (go) begin
            if (w == 3'b001) exp_player = 1'b0;
            else if (w == 3'b100) exp_player = 1'b1;
        end else if (lg) exp_player = ~exp_player;
        sb.push_back('{exp_player, req});
    endtask

    // Monitor: compares after the register update of the following edge.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(player, it.val, it.req);
            end
        end
    end

    initial begin
        #(PERIOD*5000);
        fails++; checks++;
        $display("FAIL watchdog: expired, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD*2 + 1);
        check(player, 1'b0, "R1 reset");
        @(negedge clk); rst = 1'b0;
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 wait follows 1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 wait follows 0");
        step(0, 1, 1, 1, 0, 0, 0, 1, 3'b001, "R2 wait overrides");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 play idle hold");
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, "R4 toggle cell 0");
        step(1, 0, 1, 1, 4, 9'h001, 0, 0, 0, "R4 toggle cell 4");
        step(1, 0, 1, 1, 8, 9'h011, 9'h000, 0, 0, "R7 toggle cell 8");
        step(1, 0, 1, 0, 2, 0, 0, 0, 0, "R3 no strobe");
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, "R3 no button");
        step(1, 0, 1, 1, 9, 0, 0, 0, 0, "R3 cursor 9");
        step(1, 0, 1, 1, 15, 0, 0, 0, 0, "R3 cursor 15");
        step(1, 0, 1, 1, 3, 9'h008, 0, 0, 0, "R3 taken by p0");
        step(1, 0, 1, 1, 5, 0, 9'h020, 0, 0, "R3 taken by p1");
        step(1, 0, 1, 1, 5, 9'h1DF, 9'h000, 0, 0, "R7 other bits ignored");
        step(1, 0, 1, 1, 6, 0, 0, 1, 3'b100, "R5 over beats move, R6 code 100");
        step(1, 0, 1, 1, 6, 0, 0, 1, 3'b001, "R6 code 001");
        step(1, 0, 1, 1, 6, 0, 0, 1, 3'b010, "R6 other code holds");
        step(1, 0, 1, 1, 1, 0, 0, 0, 0, "R4 toggle after over");
        step(1, 0, 1, 1, 1, 0, 0, 1, 3'b000, "R5 code 000 holds");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 hold");
        @(negedge clk);
        @(negedge clk);
        #(PERIOD/8);
        rst = 1'b1;
        #1;
        check(player, 1'b0, "R1 async reset");
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule